// File: doc/BRIEF.md
# IrDA SIR Pulse Encoder

This block turns the serial bit stream of a UART transmitter into the pulse train that drives an infrared emitter for serial-infrared links. The block runs on the system clock. A one-cycle enable marks each tick at sixteen times the baud rate, so every bit cell is sixteen ticks long. A one bit on the line produces no light. A zero bit produces one short high pulse, placed at a fixed phase inside the cell.

A mode input chooses the pulse width. In the short mode, the pulse covers three ticks, which is 3/16 of the bit period, and tracks the baud rate. In the fixed mode, the pulse lasts a set number of system clocks, chosen by a parameter, so its duration stays the same at any baud rate. The mode is taken at the moment a pulse starts. When the line is high, the tick counter stays cleared, so every run of zero bits is aligned to the falling edge of the data.

Top module: `irenc_sir_encoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `ir_out` is 0.
- R2: Any cycle with `ser_in` high forces `ir_out` to 0 on the next clock edge and clears the tick phase. After a high of any length, even one clock with no tick, the next low run counts its ticks again from the first.
- R3: With `ser_in` low and `fixed_mode` 0, `ir_out` goes to 1 on the clock edge where the enable marks the 7th tick after the data went low.
- R4: In the short mode, `ir_out` returns to 0 on the edge of the 10th tick, so the pulse is three tick periods wide.
- R5: The phase wraps after 16 ticks. A run of several zero bits gives one pulse per cell, each from tick 7 to tick 10 of its own cell. Clocks without the enable do not move the phase.
- R6: With `fixed_mode` 1 at the 7th tick, `ir_out` rises on that edge and stays high for exactly `FIXED_CYCLES` system clocks, whatever the enable does in that time.
- R7: The mode is captured at the edge where a pulse starts. A change of `fixed_mode` during a pulse has no effect on the width of that pulse.
- R8: If `ser_in` goes high while a pulse is in progress, in either mode, `ir_out` drops on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16_en | input | 1 | One-cycle enable at 16 times the baud rate |
| ser_in | input | 1 | UART serial data, idle high |
| fixed_mode | input | 1 | 0: 3/16 bit-period pulse; 1: pulse of `FIXED_CYCLES` clocks |
| ir_out | output | 1 | Registered drive to the infrared emitter, high means light on |

## Verification
Two events can arrive in the same clock: the data line going high and an edge that would continue or start a pulse. This happens when the return to high falls on a tick, or when the line goes high in the middle of a live short or fixed pulse. The bench makes this happen by ending a zero run after 8 ticks in the short mode and after 7 ticks in the fixed mode. It expects the output low on the next edge. It also checks that the following run counts from tick 1 again. The second case is a mode change in the same window as a pulse start. Here `fixed_mode` is flipped on the clock right after the 7th tick, and the pulse is checked to keep the width of the mode it started with.

// File: rtl/irenc_pkg.sv
package irenc_pkg;

    // Kind of pulse currently being emitted; captured at pulse start
    typedef enum logic [1:0] {
        PK_IDLE  = 2'd0,
        PK_SHORT = 2'd1,
        PK_FIXED = 2'd2
    } pulse_kind_e;

    // Per-edge events produced by the bit-cell phase tracker
    typedef struct packed {
        logic rise;   // this edge lands on the pulse-start tick
        logic fall;   // this edge lands on the short-pulse end tick
    } cell_evt_t;

    // Counter width able to hold values 0 .. n-1 (at least one bit)
    function automatic int unsigned width_for(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/irenc_phase.sv
module irenc_phase
    import irenc_pkg::*;
#(
    parameter int unsigned CELL_TICKS = 16,
    parameter int unsigned RISE_TICK  = 7,
    parameter int unsigned FALL_TICK  = 10,
    parameter int unsigned PW         = width_for(CELL_TICKS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic          ser_in,
    output logic [PW-1:0] phase,
    output cell_evt_t     evt
);

    logic [PW-1:0] phase_q;
    logic [PW-1:0] phase_inc;
    logic          advance;

    // Phase only moves on ticks while the line carries a zero
    assign advance = tick_en & ~ser_in;

    generate
        if ((CELL_TICKS & (CELL_TICKS - 1)) == 0) begin : g_wrap_pow2
            // Natural roll-over of the counter is the cell wrap
            assign phase_inc = phase_q + 1'b1;
        end else begin : g_wrap_cmp
            assign phase_inc = (phase_q == PW'(CELL_TICKS - 1)) ? '0 : phase_q + 1'b1;
        end
    endgenerate

    always_comb begin
        evt.rise = advance && (phase_inc == PW'(RISE_TICK));
        evt.fall = advance && (phase_inc == PW'(FALL_TICK));
    end

    always_ff @(posedge clk) begin
        if (rst || ser_in) begin
            phase_q <= '0;
        end else if (advance) begin
            phase_q <= phase_inc;
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/irenc_shaper.sv
module irenc_shaper
    import irenc_pkg::*;
#(
    parameter int unsigned FIXED_CYCLES = 3,
    parameter int unsigned LW           = width_for(FIXED_CYCLES)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ser_in,
    input  logic        fixed_mode,
    input  cell_evt_t   evt,
    output logic        ir_out,
    output pulse_kind_e kind
);

    typedef struct packed {
        logic          level;
        pulse_kind_e   kind;
        logic [LW-1:0] rem;    // clocks left after the current one (fixed mode)
    } shaper_t;

    localparam shaper_t IDLE_S = '{level: 1'b0, kind: PK_IDLE, rem: '0};

    shaper_t cur, nxt;

    always_comb begin
        nxt = cur;
        if (ser_in) begin
            nxt = IDLE_S;
        end else if (evt.rise) begin
            nxt.level = 1'b1;
            nxt.kind  = fixed_mode ? PK_FIXED : PK_SHORT;
            nxt.rem   = LW'(FIXED_CYCLES - 1);
        end else begin
            unique case (cur.kind)
                PK_SHORT: begin
                    if (evt.fall) nxt = IDLE_S;
                end
                PK_FIXED: begin
                    if (cur.rem == '0) nxt = IDLE_S;
                    else               nxt.rem = cur.rem - 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= IDLE_S;
        else     cur <= nxt;
    end

    assign ir_out = cur.level;
    assign kind   = cur.kind;

endmodule

// File: rtl/irenc_sir_encoder.sv
module irenc_sir_encoder
    import irenc_pkg::*;
#(
    parameter int unsigned CELL_TICKS   = 16,
    parameter int unsigned RISE_TICK    = 7,
    parameter int unsigned FALL_TICK    = 10,
    parameter int unsigned FIXED_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick16_en,
    input  logic ser_in,
    input  logic fixed_mode,
    output logic ir_out
);

    localparam int unsigned PW = width_for(CELL_TICKS);
    localparam int unsigned LW = width_for(FIXED_CYCLES);

    logic [PW-1:0] phase_w;
    cell_evt_t     evt_w;
    pulse_kind_e   kind_w;

    irenc_phase #(
        .CELL_TICKS (CELL_TICKS),
        .RISE_TICK  (RISE_TICK),
        .FALL_TICK  (FALL_TICK),
        .PW         (PW)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick16_en),
        .ser_in  (ser_in),
        .phase   (phase_w),
        .evt     (evt_w)
    );

    irenc_shaper #(
        .FIXED_CYCLES (FIXED_CYCLES),
        .LW           (LW)
    ) u_shaper (
        .clk        (clk),
        .rst        (rst),
        .ser_in     (ser_in),
        .fixed_mode (fixed_mode),
        .evt        (evt_w),
        .ir_out     (ir_out),
        .kind       (kind_w)
    );

endmodule

// File: rtl/irenc_sir_encoder_chk.sv
module irenc_sir_encoder_chk
    import irenc_pkg::*;
#(
    parameter int unsigned CELL_TICKS   = 16,
    parameter int unsigned RISE_TICK    = 7,
    parameter int unsigned FALL_TICK    = 10,
    parameter int unsigned FIXED_CYCLES = 3,
    parameter int unsigned PW           = width_for(CELL_TICKS)
) (
    input logic          clk,
    input logic          rst,
    input logic          tick16_en,
    input logic          ser_in,
    input logic          ir_out,
    input logic [PW-1:0] phase,
    input pulse_kind_e   kind
);

    // Length of the current high run, saturating
    logic [15:0] hi_run;
    always_ff @(posedge clk) begin
        if (rst || !ir_out)    hi_run <= '0;
        else if (hi_run != '1) hi_run <= hi_run + 1'b1;
    end

    AST_RESET_DARK: assert property (@(posedge clk) rst |=> !ir_out); // R1

    AST_IDLE_DARK: assert property (@(posedge clk) disable iff (rst)
        ser_in |=> !ir_out); // R2

    AST_PHASE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        ser_in |=> (phase == '0)); // R2

    AST_RISE_ON_SEVENTH: assert property (@(posedge clk) disable iff (rst)
        $rose(ir_out) |-> (int'(phase) == int'(RISE_TICK))); // R3

    AST_SHORT_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (ir_out && kind == PK_SHORT) |->
            (int'(phase) >= int'(RISE_TICK) && int'(phase) < int'(FALL_TICK))); // R4

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick16_en && !ser_in) |=>
            (int'(phase) == (int'($past(phase)) + 1) % int'(CELL_TICKS))); // R5

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick16_en && !ser_in) |=> $stable(phase)); // R5

    AST_FIXED_LEN: assert property (@(posedge clk) disable iff (rst)
        (kind == PK_FIXED) |-> (int'(hi_run) < int'(FIXED_CYCLES))); // R6

    AST_KIND_HELD: assert property (@(posedge clk) disable iff (rst)
        (ir_out && !$rose(ir_out)) |-> $stable(kind)); // R7

    AST_ABORT_DROP: assert property (@(posedge clk) disable iff (rst)
        (ir_out && ser_in) |=> !ir_out); // R8

endmodule

bind irenc_sir_encoder irenc_sir_encoder_chk #(
    .CELL_TICKS   (CELL_TICKS),
    .RISE_TICK    (RISE_TICK),
    .FALL_TICK    (FALL_TICK),
    .FIXED_CYCLES (FIXED_CYCLES),
    .PW           (PW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick16_en (tick16_en),
    .ser_in    (ser_in),
    .ir_out    (ir_out),
    .phase     (phase_w),
    .kind      (kind_w)
);

// File: tb/sim_irenc_sir_encoder.sv
module sim_irenc_sir_encoder;

    localparam int TP   = 4;   // system clocks per 16x tick
    localparam int FIXC = 5;   // fixed pulse length in clocks
    localparam int CELL = 16;
    localparam int RISE = 7;

    logic clk        = 1'b0;
    logic rst        = 1'b1;
    logic tick16_en  = 1'b0;
    logic ser_in     = 1'b1;
    logic fixed_mode = 1'b0;
    logic ir_out;

    always #5 clk = ~clk;

    irenc_sir_encoder #(.FIXED_CYCLES(FIXC)) u0 (
        .clk        (clk),
        .rst        (rst),
        .tick16_en  (tick16_en),
        .ser_in     (ser_in),
        .fixed_mode (fixed_mode),
        .ir_out     (ir_out)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Scoreboard: expected output per target cycle
    int    q_cyc[$];
    bit    q_val[$];
    string q_req[$];
    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 1'b0;

    always @(negedge clk) begin
        while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            n_chk++;
            if (ir_out !== q_val[0]) begin
                n_err++;
                $display("FAIL %s cycle %0d: ir_out=%b expected=%b",
                         q_req[0], q_cyc[0], ir_out, q_val[0]);
            end
            void'(q_cyc.pop_front());
            void'(q_val.pop_front());
            void'(q_req.pop_front());
        end
    end

    task automatic drive(bit r, bit t, bit s, bit m, bit e, string req);
        @(posedge clk);
        #2;
        rst        = r;
        tick16_en  = t;
        ser_in     = s;
        fixed_mode = m;
        q_cyc.push_back(cyc + 1);
        q_val.push_back(e);
        q_req.push_back(req);
    endtask

    // Line high for n clocks, ticks every TP clocks; output must stay dark
    task automatic run_high(int n, string req);
        for (int i = 0; i < n; i++) drive(1'b0, (i % TP) == 0, 1'b1, 1'b0, 1'b0, req);
    endtask

    // Line low for nt ticks from a cleared phase. ms: mode at pulse start,
    // ml: mode driven after the start clock of each pulse.
    task automatic run_low(int nt, bit ms, bit ml, string req);
        for (int k = 0; k < nt; k++) begin
            for (int j = 0; j < TP; j++) begin
                int t;
                int c;
                bit m;
                bit e;
                t = (k % CELL) + 1;
                c = (t - 1) * TP + j;
                m = (c > (RISE - 1) * TP) ? ml : ms;
                if (ms) e = (c >= (RISE - 1) * TP) && (c < (RISE - 1) * TP + FIXC);
                else    e = (t >= 7) && (t <= 9);
                drive(1'b0, j == 0, 1'b0, m, e, req);
            end
        end
    endtask

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R1");
        // R2: idle line stays dark
        run_high(8, "R2");
        // R3, R4: single short-mode zero bit
        run_low(16, 1'b0, 1'b0, "R3,R4");
        run_high(12, "R2");
        // R5: three back-to-back zero bits
        run_low(48, 1'b0, 1'b0, "R5");
        run_high(8, "R2");
        // R2: one-clock high glitch restarts the tick count
        run_low(3, 1'b0, 1'b0, "R2");
        run_high(1, "R2");
        run_low(16, 1'b0, 1'b0, "R2");
        run_high(8, "R2");
        // R6: fixed-width pulses, one and two cells
        run_low(16, 1'b1, 1'b1, "R6");
        run_high(8, "R6");
        run_low(32, 1'b1, 1'b1, "R6");
        run_high(8, "R6");
        // R7: mode flipped during a pulse
        run_low(16, 1'b0, 1'b1, "R7");
        run_high(8, "R7");
        run_low(16, 1'b1, 1'b0, "R7");
        run_high(8, "R7");
        // R8: line returns high mid-pulse
        run_low(8, 1'b0, 1'b0, "R8");
        run_high(8, "R8");
        run_low(7, 1'b1, 1'b1, "R8");
        run_high(8, "R8");
        run_low(16, 1'b0, 1'b0, "R8");
        run_high(4, "R8");
        wait (q_cyc.size() == 0);
        @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule